// File: doc/BRIEF.md
# Register Rename Map with Free Pool

This block sits at dispatch in a small out-of-order core and swaps architectural register numbers for physical tags. In each cycle it takes one decoded instruction carrying two source register numbers and an optional destination. It returns the physical tag that currently holds each source. When the instruction writes a register, it also returns a freshly allocated physical tag for the destination, together with the tag that destination used to map to. Because every write gets a new physical home, a later instruction that reuses an architectural register can no longer overwrite a value an earlier reader still needs. It also cannot race an earlier writer of the same register.

The block has eight architectural registers and sixteen physical ones. A map table holds the current architectural-to-physical binding. The unmapped physical tags wait in a circular FIFO, the free pool. Commit logic returns a tag through the release port once a newer write has superseded its value and no reader still refers to it. The pool occupancy is tracked by a three-state machine:

- POOL_FULL: all eight spare tags are present. This is the reset state.
- POOL_PARTIAL: some spare tags are present, but not all eight.
- POOL_EMPTY: no spare tag is present, and the block stalls.

The transitions are:

- take_last: POOL_PARTIAL goes to POOL_EMPTY when the last tag is allocated.
- refill_first: POOL_EMPTY goes to POOL_PARTIAL on a release.
- return_last: POOL_PARTIAL goes to POOL_FULL when the eighth tag comes back.
- take_first: POOL_FULL goes to POOL_PARTIAL on an allocation with no release.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i maps to physical tag i for every i from 0 to 7. The pool holds tags 8 through 15, handed out in ascending order, and `rename_ready` is 1.
- R2: The source tags of an instruction come from the map as it stood before that same instruction's destination is remapped. For example, r3 := r3 op r5 reads tag 3 for r3, even while it allocates a new tag for r3.
- R3: An accepted instruction with a nonzero destination receives the tag at the head of the free pool. Every later instruction that reads that architectural register sees the new tag.
- R4: `out_prev` carries the physical tag the destination was bound to just before the rename, and it never equals `out_dst`.
- R5: If `in_dst_en` is 0 or `in_dst` is 0, nothing is allocated, and `out_dst` and `out_prev` are both 0. Architectural register 0 always reads physical tag 0.
- R6: While the pool is empty, `rename_ready` is 0. An instruction presented in that cycle changes neither the map nor the pool.
- R7: A released tag joins the tail of the pool at the next clock edge. A release and an allocation may happen in the same cycle. A release into an empty pool makes `rename_ready` 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_src_a | input | 3 | First source architectural register |
| in_src_b | input | 3 | Second source architectural register |
| in_dst_en | input | 1 | The instruction writes a destination |
| in_dst | input | 3 | Destination architectural register |
| rename_ready | output | 1 | Pool not empty; a valid instruction is accepted this cycle |
| out_src_a | output | 4 | Physical tag of the first source |
| out_src_b | output | 4 | Physical tag of the second source |
| out_dst | output | 4 | Newly allocated destination tag, or 0 |
| out_prev | output | 4 | Tag the destination was bound to before this rename, or 0 |
| rel_valid | input | 1 | Return a tag to the pool |
| rel_tag | input | 4 | Tag being returned |

## Verification
The bench targets the self-referencing instruction r3 := r3 op r5. A design that remapped before the lookup would hand the new tag back as the source. The bench drains the pool and then presents an instruction while it is empty. A design that allocated anyway would issue a stale head tag and corrupt the map, and the next source lookup exposes this. It releases into an empty pool, and also releases and allocates in the same cycle when one tag is left. A wrong FIFO pointer or a wrong count would then return the wrong tag or stay stalled. Writes to register 0 and instructions without a destination are mixed into a long pseudo-random run, where a leaked allocation shifts the expected tag order.

// File: rtl/rn_pkg.sv
package rn_pkg;
    parameter int ARCH_REGS = 8;
    parameter int PHYS_REGS = 16;

    localparam int AW         = $clog2(ARCH_REGS);
    localparam int PW         = $clog2(PHYS_REGS);
    localparam int SPARE_TAGS = PHYS_REGS - ARCH_REGS;

    typedef enum logic [1:0] {
        POOL_EMPTY   = 2'd0,
        POOL_PARTIAL = 2'd1,
        POOL_FULL    = 2'd2
    } pool_state_e;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int NREG = 8,
    parameter int AW   = 3,
    parameter int PW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a,
    input  logic [AW-1:0] rd_b,
    input  logic [AW-1:0] rd_c,
    output logic [PW-1:0] tag_a,
    output logic [PW-1:0] tag_b,
    output logic [PW-1:0] tag_c,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_reg,
    input  logic [PW-1:0] wr_tag
);
    logic [PW-1:0] binding [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                binding[i] <= PW'(i);
            end
        end else if (wr_en) begin
            binding[wr_reg] <= wr_tag;
        end
    end

    // Reads see the table before this cycle's write lands.
    assign tag_a = binding[rd_a];
    assign tag_b = binding[rd_b];
    assign tag_c = binding[rd_c];
endmodule

// File: rtl/rn_free_pool.sv
module rn_free_pool
    import rn_pkg::*;
#(
    parameter int PW    = 4,
    parameter int DEPTH = 8,
    parameter int FIRST = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          give,
    input  logic [PW-1:0] give_tag,
    output logic [PW-1:0] head_tag,
    output logic          avail
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    pool_state_e   state, state_nx;
    logic [PW-1:0] slots [DEPTH];
    logic [IW-1:0] rd_ptr, wr_ptr;
    logic [LW-1:0] level;
    logic          do_take, do_give;

    function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_take = take && (state != POOL_EMPTY);
    assign do_give = give && ((state != POOL_FULL) || do_take);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= POOL_FULL;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            POOL_EMPTY: begin
                if (do_give) state_nx = (DEPTH == 1) ? POOL_FULL : POOL_PARTIAL;   // refill_first
            end
            POOL_PARTIAL: begin
                if (do_take && !do_give && level == LW'(1))
                    state_nx = POOL_EMPTY;                                       // take_last
                else if (do_give && !do_take && level == LW'(DEPTH - 1))
                    state_nx = POOL_FULL;                                        // return_last
            end
            POOL_FULL: begin
                if (do_take && !do_give) state_nx = (DEPTH == 1) ? POOL_EMPTY : POOL_PARTIAL; // take_first
            end
            default: state_nx = POOL_FULL;
        endcase
    end

    // Outputs
    always_comb begin
        avail    = (state != POOL_EMPTY);
        head_tag = slots[rd_ptr];
    end

    // Storage and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                slots[k] <= PW'(FIRST + k);
            end
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= LW'(DEPTH);
        end else begin
            if (do_give) begin
                slots[wr_ptr] <= give_tag;
                wr_ptr        <= bump(wr_ptr);
            end
            if (do_take) begin
                rd_ptr <= bump(rd_ptr);
            end
            if (do_give && !do_take) level <= level + 1'b1;
            else if (do_take && !do_give) level <= level - 1'b1;
        end
    end
endmodule

// File: rtl/reg_rename.sv
module reg_rename
    import rn_pkg::*;
#(
    parameter int NARCH = ARCH_REGS,
    parameter int NPHYS = PHYS_REGS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [$clog2(NARCH)-1:0]   in_src_a,
    input  logic [$clog2(NARCH)-1:0]   in_src_b,
    input  logic                       in_dst_en,
    input  logic [$clog2(NARCH)-1:0]   in_dst,
    output logic                       rename_ready,
    output logic [$clog2(NPHYS)-1:0]   out_src_a,
    output logic [$clog2(NPHYS)-1:0]   out_src_b,
    output logic [$clog2(NPHYS)-1:0]   out_dst,
    output logic [$clog2(NPHYS)-1:0]   out_prev,
    input  logic                       rel_valid,
    input  logic [$clog2(NPHYS)-1:0]   rel_tag
);
    localparam int LAW = $clog2(NARCH);
    localparam int LPW = $clog2(NPHYS);

    logic           needs_tag, pool_avail, alloc;
    logic [LPW-1:0] head_tag, cur_dst_tag;

    assign needs_tag    = in_dst_en && (in_dst != '0);
    assign rename_ready = pool_avail;
    assign alloc        = in_valid && pool_avail && needs_tag;

    rn_map_table #(.NREG(NARCH), .AW(LAW), .PW(LPW)) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_a   (in_src_a),
        .rd_b   (in_src_b),
        .rd_c   (in_dst),
        .tag_a  (out_src_a),
        .tag_b  (out_src_b),
        .tag_c  (cur_dst_tag),
        .wr_en  (alloc),
        .wr_reg (in_dst),
        .wr_tag (head_tag)
    );

    rn_free_pool #(.PW(LPW), .DEPTH(NPHYS - NARCH), .FIRST(NARCH)) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (alloc),
        .give     (rel_valid),
        .give_tag (rel_tag),
        .head_tag (head_tag),
        .avail    (pool_avail)
    );

    assign out_dst  = needs_tag ? head_tag    : '0;
    assign out_prev = needs_tag ? cur_dst_tag : '0;
endmodule

// File: rtl/rn_chk.sv
module rn_chk #(
    parameter int AW = 3,
    parameter int PW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_dst_en,
    input logic [AW-1:0] in_dst,
    input logic [AW-1:0] in_src_a,
    input logic          rename_ready,
    input logic [PW-1:0] out_src_a,
    input logic [PW-1:0] out_dst,
    input logic [PW-1:0] out_prev,
    input logic          rel_valid
);
    // R5
    no_dst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rename_ready && (!in_dst_en || in_dst == '0)) |-> (out_dst == '0 && out_prev == '0));

    // R5
    zero_reg_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_src_a == '0) |-> (out_src_a == '0));

    // R4
    fresh_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rename_ready && in_dst_en && in_dst != '0) |-> (out_dst != out_prev && out_dst != '0));

    // R6
    empty_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rename_ready && !rel_valid) |=> !rename_ready);

    // R7
    release_refills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |=> rename_ready);
endmodule

bind reg_rename rn_chk #(.AW($clog2(NARCH)), .PW($clog2(NPHYS))) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_dst_en    (in_dst_en),
    .in_dst       (in_dst),
    .in_src_a     (in_src_a),
    .rename_ready (rename_ready),
    .out_src_a    (out_src_a),
    .out_dst      (out_dst),
    .out_prev     (out_prev),
    .rel_valid    (rel_valid)
);

// File: tb/reg_rename_tb.sv
`timescale 1ns/1ps
module reg_rename_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_dst_en = 1'b0, rel_valid = 1'b0;
    logic [2:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
    logic [3:0] rel_tag = '0;
    logic       rename_ready;
    logic [3:0] out_src_a, out_src_b, out_dst, out_prev;

    always #2 clk = ~clk;

    reg_rename u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src_a(in_src_a),
        .in_src_b(in_src_b), .in_dst_en(in_dst_en), .in_dst(in_dst),
        .rename_ready(rename_ready), .out_src_a(out_src_a), .out_src_b(out_src_b),
        .out_dst(out_dst), .out_prev(out_prev), .rel_valid(rel_valid), .rel_tag(rel_tag)
    );

    typedef struct {
        logic       rdy;
        logic       tags;
        logic [3:0] sa, sb, d, p;
        string      req;
    } exp_t;

    exp_t q[$];
    int   amap[8];
    int   fpool[$];
    int   pending[$];
    int   n_run = 0, n_fail = 0;
    bit   done = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver: present one cycle of stimulus and queue what must come out.
    task automatic step(input bit v, input int a, input int b, input bit de, input int d,
                        input bit rv, input int rt, input string req);
        exp_t e;
        bit   need;
        @(negedge clk);
        in_valid  = v;   in_src_a = 3'(a); in_src_b = 3'(b);
        in_dst_en = de;  in_dst = 3'(d);
        rel_valid = rv;  rel_tag = 4'(rt);
        need   = de && (d != 0);
        e.req  = req;
        e.rdy  = (fpool.size() != 0);
        e.tags = v && e.rdy;
        e.sa   = 4'(amap[a]);
        e.sb   = 4'(amap[b]);
        e.d    = need ? 4'(fpool[0]) : 4'd0;
        e.p    = need ? 4'(amap[d]) : 4'd0;
        if (e.tags && need) begin
            void'(fpool.pop_front());
            amap[d] = e.d;
            pending.push_back(int'(e.p));
        end
        if (rv) fpool.push_back(rt);
        q.push_back(e);
    endtask

    // Monitor: compare combinational outputs mid-cycle.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                chk(e.req, "ready", rename_ready, e.rdy);
                if (e.tags) begin
                    chk(e.req, "src_a", out_src_a, e.sa);
                    chk(e.req, "src_b", out_src_b, e.sb);
                    chk(e.req, "dst",   out_dst,   e.d);
                    chk(e.req, "prev",  out_prev,  e.p);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int lf = 32'h1d3;
        for (int i = 0; i < 8; i++) amap[i] = i;
        for (int i = 8; i < 16; i++) fpool.push_back(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "ready after reset", rename_ready, 1);

        // R1, R2: r3 := r3 op r5 reads old tags, takes tag 8
        step(1, 3, 5, 1, 3, 0, 0, "R2");
        // R3: reader of r3 sees 8
        step(1, 3, 0, 1, 4, 0, 0, "R3");
        // R4: r3 rewritten, previous tag 8
        step(1, 5, 0, 1, 3, 0, 0, "R4");
        // R5: no destination, then destination register 0
        step(1, 0, 3, 0, 5, 0, 0, "R5");
        step(1, 1, 2, 1, 0, 0, 0, "R5");
        // R3: drain the rest of the pool
        for (int i = 0; i < 5; i++) step(1, (i + 2) % 8, (i + 5) % 8, 1, (i % 7) + 1, 0, 0, "R3");
        // R6: empty, instruction presented and refused
        step(1, 6, 1, 1, 6, 0, 0, "R6");
        // R7: release into an empty pool; still stalled this cycle
        step(1, 6, 6, 1, 6, 1, pending.pop_front(), "R7");
        // R6/R7: map unchanged by stalled attempts, released tag handed out
        step(1, 6, 7, 1, 6, 0, 0, "R7");
        // R7: last tag, release and allocate together
        step(1, 2, 3, 1, 2, 1, pending.pop_front(), "R7");
        step(1, 2, 4, 1, 1, 1, pending.pop_front(), "R7");
        step(1, 1, 2, 1, 7, 0, 0, "R7");
        // Mixed run
        for (int i = 0; i < 300; i++) begin
            bit rv;
            int rt;
            lf = (lf >> 1) ^ ((lf & 1) ? 32'hB400 : 0);
            rv = (pending.size() > 0) && (lf[3:2] != 2'b00);
            rt = rv ? pending[0] : 0;
            if (rv) void'(pending.pop_front());
            step(lf[0], lf[6:4], lf[9:7], lf[1] | lf[10], lf[13:11], rv, rt, "R3");
        end
        @(negedge clk);
        in_valid = 0; rel_valid = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule